// File: doc/BRIEF.md
# Filter Input Buffer Controller

This block is the staging stage in front of a decimation filter datapath. It takes words from one of two sources: a converter result stream, or a processor/DMA register write. A select input picks the source. Each word is tagged as either a sample or a timestamp. A sample that meets an idle filter goes straight to the tap input register. A timestamp that meets an empty timestamp register goes straight into that register. Any word that cannot move on at once waits in a one-word input buffer, and it leaves the buffer as soon as the register it needs is free.

The filter core reports the end of each sample's processing with a one-cycle done pulse. It frees the timestamp register with a take pulse. The controller raises buffer-empty service requests for the processor path, either as a DMA request or as an interrupt, with DMA taking priority. It keeps a sticky data-received flag and a sticky overrun flag, each cleared by a write-one strobe. An overrun drops the newest word and leaves the buffered word in place.

Top module: `fltin_ctrl`

## Requirements
- R1: When `src_sel` is 1, words are taken from the converter port (`cnv_valid`, `cnv_stamp`, `cnv_data`). When it is 0, words are taken from the processor port (`cpu_wr`, `cpu_stamp`, `cpu_data`). Words on the port that is not selected have no effect. A stamp bit of 1 marks a timestamp and 0 marks a sample.
- R2: A sample that arrives while the buffer is empty and `filt_busy` is low loads `tap_data`. `tap_load` is high for exactly the one cycle after the arrival, and `filt_busy` goes high at the same time. `filt_busy` falls in the cycle after a `core_done` pulse.
- R3: A timestamp that arrives while the buffer is empty and `ts_valid` is low loads `ts_data`, and `ts_valid` is high from the next cycle on. `ts_data` holds its value until a `ts_take` pulse, and `ts_valid` falls in the cycle after that pulse.
- R4: A word that cannot be forwarded waits in the buffer (`buf_full` high). It moves to its register on the first clock edge at which that register is free. A buffered sample then raises `tap_load` and `filt_busy` together, and `buf_full` falls at the same time.
- R5: Starting from idle with all registers empty, back-to-back inputs of sample, timestamp, sample (and also of two samples) produce no overrun. The last sample waits in the buffer.
- R6: An overrun occurs when the buffer holds a sample, the filter is busy, and any new word arrives. The new word is dropped and the buffered word is kept.
- R7: An overrun occurs when the buffer holds a timestamp, the timestamp register is loaded, and a new word arrives. The new word is dropped and the buffered timestamp is kept.
- R8: An overrun sets `ovr_flag`, which stays set until an `ovr_clr` pulse. `err_irq` is high exactly when `ovr_flag` and `err_ie` are both high.
- R9: `dma_req` is high while the processor source is selected, the buffer is empty, and `dma_sel` is 1.
- R10: `empty_irq` is high while the processor source is selected, the buffer is empty, `empty_ie` is 1 and `dma_sel` is 0. `dma_req` and `empty_irq` are never high together.
- R11: An arriving word sets `data_flag` on the next edge only when `data_ie` is 1. The flag stays set after the word has been consumed, until a `data_clr` pulse.
- R12: A synchronous `rst` clears the buffer, both registers' valid state, `filt_busy`, `tap_load`, both flags and all requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| src_sel | input | 1 | 1 = converter source, 0 = processor source |
| cnv_valid | input | 1 | Converter word present |
| cnv_stamp | input | 1 | Converter word is a timestamp |
| cnv_data | input | DW | Converter word |
| cpu_wr | input | 1 | Processor/DMA write strobe |
| cpu_stamp | input | 1 | Processor word is a timestamp |
| cpu_data | input | DW | Processor word |
| dma_sel | input | 1 | Empty-buffer service by DMA |
| empty_ie | input | 1 | Empty-buffer interrupt enable |
| data_ie | input | 1 | Data-received flag enable |
| err_ie | input | 1 | Overrun interrupt enable |
| data_clr | input | 1 | Write-one clear of data_flag |
| ovr_clr | input | 1 | Write-one clear of ovr_flag |
| core_done | input | 1 | Filter finished the current sample |
| ts_take | input | 1 | Filter consumed the timestamp register |
| tap_load | output | 1 | One-cycle pulse: tap_data newly loaded |
| tap_data | output | DW | Tap input register |
| filt_busy | output | 1 | Filter processing a sample |
| ts_valid | output | 1 | Timestamp register loaded |
| ts_data | output | DW | Timestamp register |
| buf_full | output | 1 | Input buffer holds a word |
| dma_req | output | 1 | DMA request for more input |
| empty_irq | output | 1 | Buffer-empty interrupt |
| data_flag | output | 1 | Sticky data-received flag |
| ovr_flag | output | 1 | Sticky overrun flag |
| err_irq | output | 1 | Overrun interrupt |

## Verification
Some properties are checked on every clock cycle:
- no tap load happens while the filter is busy;
- the buffered word and the timestamp register hold still while they are blocked;
- the two service requests are mutually exclusive;
- both flags are sticky, and the data flag cannot set with its enable low.

Other behaviour can only be shown by the directed scenarios:
- the order in which words are forwarded, and their data values;
- which word is dropped on each kind of overrun;
- the legal sample–timestamp–sample sequence;
- the source selection;
- the clearing of state on reset.

// File: rtl/fltin_pkg.sv
package fltin_pkg;
   typedef enum logic {
      WK_SAMPLE = 1'b0,
      WK_STAMP  = 1'b1
   } word_kind_e;

   localparam int unsigned MAX_DW = 64;
endpackage

// File: rtl/fltin_srcmux.sv
module fltin_srcmux
   import fltin_pkg::*;
#(
   parameter int unsigned DW      = 16,
   parameter bit          CNV_SEL = 1'b1
) (
   input  logic          src_sel,
   input  logic          cnv_valid,
   input  logic          cnv_stamp,
   input  logic [DW-1:0] cnv_data,
   input  logic          cpu_wr,
   input  logic          cpu_stamp,
   input  logic [DW-1:0] cpu_data,
   output logic          in_vld,
   output word_kind_e    in_kind,
   output logic [DW-1:0] in_data,
   output logic          proc_sel
);
   logic use_cnv;

   assign use_cnv  = (src_sel == CNV_SEL);
   assign proc_sel = !use_cnv;
   assign in_vld   = use_cnv ? cnv_valid : cpu_wr;
   assign in_kind  = word_kind_e'(use_cnv ? cnv_stamp : cpu_stamp);
   assign in_data  = use_cnv ? cnv_data : cpu_data;
endmodule

// File: rtl/fltin_stage.sv
module fltin_stage
   import fltin_pkg::*;
#(
   parameter int unsigned DW = 16
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          in_vld,
   input  word_kind_e    in_kind,
   input  logic [DW-1:0] in_data,
   input  logic          core_done,
   input  logic          ts_take,
   output logic          tap_load,
   output logic [DW-1:0] tap_data,
   output logic          busy,
   output logic          ts_vld,
   output logic [DW-1:0] ts_data,
   output logic          buf_vld,
   output logic          ovr_evt
);
   logic          buf_vld_q;
   word_kind_e    buf_kind_q;
   logic [DW-1:0] buf_data_q;
   logic          busy_q;
   logic          ts_vld_q;
   logic [DW-1:0] ts_data_q;
   logic [DW-1:0] tap_data_q;
   logic          tap_load_q;

   logic          drain;
   logic          to_tap;
   logic          to_ts;
   logic          ld_tap;
   logic          ld_ts;
   logic          hold_new;
   logic [DW-1:0] fwd_data;

   always_comb begin
      drain  = buf_vld_q && ((buf_kind_q == WK_STAMP) ? !ts_vld_q : !busy_q);
      to_tap = in_vld && (in_kind == WK_SAMPLE) && !busy_q;
      to_ts  = in_vld && (in_kind == WK_STAMP) && !ts_vld_q;
      if (buf_vld_q) begin
         ld_tap   = drain && (buf_kind_q == WK_SAMPLE);
         ld_ts    = drain && (buf_kind_q == WK_STAMP);
         hold_new = drain && in_vld;
         fwd_data = buf_data_q;
      end else begin
         ld_tap   = to_tap;
         ld_ts    = to_ts;
         hold_new = in_vld && !to_tap && !to_ts;
         fwd_data = in_data;
      end
      ovr_evt = buf_vld_q && !drain && in_vld;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         buf_vld_q  <= 1'b0;
         buf_kind_q <= WK_SAMPLE;
         buf_data_q <= '0;
         busy_q     <= 1'b0;
         ts_vld_q   <= 1'b0;
         ts_data_q  <= '0;
         tap_data_q <= '0;
         tap_load_q <= 1'b0;
      end else begin
         tap_load_q <= ld_tap;
         if (ld_tap) begin
            tap_data_q <= fwd_data;
         end
         if (ld_tap) begin
            busy_q <= 1'b1;
         end else if (core_done) begin
            busy_q <= 1'b0;
         end
         if (ld_ts) begin
            ts_vld_q  <= 1'b1;
            ts_data_q <= fwd_data;
         end else if (ts_take) begin
            ts_vld_q <= 1'b0;
         end
         if (hold_new) begin
            buf_vld_q  <= 1'b1;
            buf_kind_q <= in_kind;
            buf_data_q <= in_data;
         end else if (drain) begin
            buf_vld_q <= 1'b0;
         end
      end
   end

   assign tap_load = tap_load_q;
   assign tap_data = tap_data_q;
   assign busy     = busy_q;
   assign ts_vld   = ts_vld_q;
   assign ts_data  = ts_data_q;
   assign buf_vld  = buf_vld_q;

   // R6
   no_load_busy_chk: assert property (@(posedge clk) disable iff (rst)
      (busy_q && !core_done) |=> !tap_load_q);

   // R6
   keep_on_ovr_chk: assert property (@(posedge clk) disable iff (rst)
      ovr_evt |=> (buf_vld_q && $stable(buf_data_q) && $stable(buf_kind_q)));

   // R3
   ts_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (ts_vld_q && !ts_take) |=> (ts_vld_q && $stable(ts_data_q)));
endmodule

// File: rtl/fltin_flags.sv
module fltin_flags #(
   parameter bit REQ_REG = 1'b0
) (
   input  logic clk,
   input  logic rst,
   input  logic proc_sel,
   input  logic buf_vld,
   input  logic in_vld,
   input  logic ovr_evt,
   input  logic dma_sel,
   input  logic empty_ie,
   input  logic data_ie,
   input  logic err_ie,
   input  logic data_clr,
   input  logic ovr_clr,
   output logic dma_req,
   output logic empty_irq,
   output logic data_flag,
   output logic ovr_flag,
   output logic err_irq
);
   logic data_flag_q;
   logic ovr_flag_q;
   logic want_svc;
   logic dma_n;
   logic irq_n;

   assign want_svc = proc_sel && !buf_vld;
   assign dma_n    = want_svc && dma_sel;
   assign irq_n    = want_svc && empty_ie && !dma_sel;

   generate
      if (REQ_REG) begin : g_req_reg
         logic dma_q;
         logic irq_q;
         always_ff @(posedge clk) begin
            if (rst) begin
               dma_q <= 1'b0;
               irq_q <= 1'b0;
            end else begin
               dma_q <= dma_n;
               irq_q <= irq_n;
            end
         end
         assign dma_req   = dma_q;
         assign empty_irq = irq_q;
      end else begin : g_req_comb
         assign dma_req   = dma_n;
         assign empty_irq = irq_n;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         data_flag_q <= 1'b0;
         ovr_flag_q  <= 1'b0;
      end else begin
         if (in_vld && data_ie) begin
            data_flag_q <= 1'b1;
         end else if (data_clr) begin
            data_flag_q <= 1'b0;
         end
         if (ovr_evt) begin
            ovr_flag_q <= 1'b1;
         end else if (ovr_clr) begin
            ovr_flag_q <= 1'b0;
         end
      end
   end

   assign data_flag = data_flag_q;
   assign ovr_flag  = ovr_flag_q;
   assign err_irq   = ovr_flag_q && err_ie;

   // R10
   req_excl_chk: assert property (@(posedge clk) disable iff (rst)
      !(dma_req && empty_irq));

   // R8
   ovr_sticky_chk: assert property (@(posedge clk) disable iff (rst)
      (ovr_flag_q && !ovr_clr) |=> ovr_flag_q);

   // R11
   dflag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
      (data_flag_q && !data_clr) |=> data_flag_q);

   // R11
   dflag_gate_chk: assert property (@(posedge clk) disable iff (rst)
      (!data_flag_q && !(in_vld && data_ie)) |=> !data_flag_q);
endmodule

// File: rtl/fltin_ctrl.sv
module fltin_ctrl
   import fltin_pkg::*;
#(
   parameter int unsigned DW      = 16,
   parameter bit          CNV_SEL = 1'b1,
   parameter bit          REQ_REG = 1'b0
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          src_sel,
   input  logic          cnv_valid,
   input  logic          cnv_stamp,
   input  logic [DW-1:0] cnv_data,
   input  logic          cpu_wr,
   input  logic          cpu_stamp,
   input  logic [DW-1:0] cpu_data,
   input  logic          dma_sel,
   input  logic          empty_ie,
   input  logic          data_ie,
   input  logic          err_ie,
   input  logic          data_clr,
   input  logic          ovr_clr,
   input  logic          core_done,
   input  logic          ts_take,
   output logic          tap_load,
   output logic [DW-1:0] tap_data,
   output logic          filt_busy,
   output logic          ts_valid,
   output logic [DW-1:0] ts_data,
   output logic          buf_full,
   output logic          dma_req,
   output logic          empty_irq,
   output logic          data_flag,
   output logic          ovr_flag,
   output logic          err_irq
);
   generate
      if (DW < 2 || DW > MAX_DW) begin : g_bad_dw
         $error("fltin_ctrl: DW out of supported range");
      end
   endgenerate

   logic          in_vld;
   word_kind_e    in_kind;
   logic [DW-1:0] in_data;
   logic          proc_sel;
   logic          buf_vld;
   logic          ovr_evt;

   fltin_srcmux #(.DW(DW), .CNV_SEL(CNV_SEL)) u_mux (
      .src_sel   (src_sel),
      .cnv_valid (cnv_valid),
      .cnv_stamp (cnv_stamp),
      .cnv_data  (cnv_data),
      .cpu_wr    (cpu_wr),
      .cpu_stamp (cpu_stamp),
      .cpu_data  (cpu_data),
      .in_vld    (in_vld),
      .in_kind   (in_kind),
      .in_data   (in_data),
      .proc_sel  (proc_sel)
   );

   fltin_stage #(.DW(DW)) u_stage (
      .clk       (clk),
      .rst       (rst),
      .in_vld    (in_vld),
      .in_kind   (in_kind),
      .in_data   (in_data),
      .core_done (core_done),
      .ts_take   (ts_take),
      .tap_load  (tap_load),
      .tap_data  (tap_data),
      .busy      (filt_busy),
      .ts_vld    (ts_valid),
      .ts_data   (ts_data),
      .buf_vld   (buf_vld),
      .ovr_evt   (ovr_evt)
   );

   fltin_flags #(.REQ_REG(REQ_REG)) u_flags (
      .clk       (clk),
      .rst       (rst),
      .proc_sel  (proc_sel),
      .buf_vld   (buf_vld),
      .in_vld    (in_vld),
      .ovr_evt   (ovr_evt),
      .dma_sel   (dma_sel),
      .empty_ie  (empty_ie),
      .data_ie   (data_ie),
      .err_ie    (err_ie),
      .data_clr  (data_clr),
      .ovr_clr   (ovr_clr),
      .dma_req   (dma_req),
      .empty_irq (empty_irq),
      .data_flag (data_flag),
      .ovr_flag  (ovr_flag),
      .err_irq   (err_irq)
   );

   assign buf_full = buf_vld;
endmodule

// File: tb/test_fltin_ctrl.sv
module test_fltin_ctrl;
   localparam int DW = 16;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          src_sel = 1'b0;
   logic          cnv_valid = 1'b0;
   logic          cnv_stamp = 1'b0;
   logic [DW-1:0] cnv_data = '0;
   logic          cpu_wr = 1'b0;
   logic          cpu_stamp = 1'b0;
   logic [DW-1:0] cpu_data = '0;
   logic          dma_sel = 1'b0;
   logic          empty_ie = 1'b0;
   logic          data_ie = 1'b0;
   logic          err_ie = 1'b0;
   logic          data_clr = 1'b0;
   logic          ovr_clr = 1'b0;
   logic          core_done = 1'b0;
   logic          ts_take = 1'b0;
   logic          tap_load;
   logic [DW-1:0] tap_data;
   logic          filt_busy;
   logic          ts_valid;
   logic [DW-1:0] ts_data;
   logic          buf_full;
   logic          dma_req;
   logic          empty_irq;
   logic          data_flag;
   logic          ovr_flag;
   logic          err_irq;

   int checks = 0;
   int failures = 0;

   always #10 clk = ~clk;

   fltin_ctrl #(.DW(DW)) i_fltin_ctrl (
      .clk(clk), .rst(rst), .src_sel(src_sel),
      .cnv_valid(cnv_valid), .cnv_stamp(cnv_stamp), .cnv_data(cnv_data),
      .cpu_wr(cpu_wr), .cpu_stamp(cpu_stamp), .cpu_data(cpu_data),
      .dma_sel(dma_sel), .empty_ie(empty_ie), .data_ie(data_ie), .err_ie(err_ie),
      .data_clr(data_clr), .ovr_clr(ovr_clr), .core_done(core_done), .ts_take(ts_take),
      .tap_load(tap_load), .tap_data(tap_data), .filt_busy(filt_busy),
      .ts_valid(ts_valid), .ts_data(ts_data), .buf_full(buf_full),
      .dma_req(dma_req), .empty_irq(empty_irq), .data_flag(data_flag),
      .ovr_flag(ovr_flag), .err_irq(err_irq)
   );

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic do_reset();
      rst = 1'b1;
      src_sel = 1'b0; cnv_valid = 1'b0; cnv_stamp = 1'b0; cpu_wr = 1'b0; cpu_stamp = 1'b0;
      dma_sel = 1'b0; empty_ie = 1'b0; data_ie = 1'b0; err_ie = 1'b0;
      data_clr = 1'b0; ovr_clr = 1'b0; core_done = 1'b0; ts_take = 1'b0;
      repeat (2) @(negedge clk);
      rst = 1'b0;
   endtask

   task automatic send(input logic stamp, input logic [DW-1:0] d);
      cpu_wr = 1'b1; cpu_stamp = stamp; cpu_data = d;
      @(negedge clk);
      cpu_wr = 1'b0; cpu_stamp = 1'b0;
   endtask

   task automatic pulse_done();
      core_done = 1'b1;
      @(negedge clk);
      core_done = 1'b0;
   endtask

   task automatic pulse_take();
      ts_take = 1'b1;
      @(negedge clk);
      ts_take = 1'b0;
   endtask

   task automatic t_reset();
      send(1'b0, 16'h0101);
      send(1'b0, 16'h0202);
      send(1'b1, 16'h0303);
      data_ie = 1'b1;
      send(1'b0, 16'h0404);
      do_reset();
      chk("R12", "tap_load", tap_load, 0);
      chk("R12", "filt_busy", filt_busy, 0);
      chk("R12", "ts_valid", ts_valid, 0);
      chk("R12", "buf_full", buf_full, 0);
      chk("R12", "ovr_flag", ovr_flag, 0);
      chk("R12", "data_flag", data_flag, 0);
      chk("R12", "dma_req", dma_req, 0);
      chk("R12", "empty_irq", empty_irq, 0);
   endtask

   task automatic t_direct();
      do_reset();
      send(1'b0, 16'h1111);
      chk("R2", "tap_load", tap_load, 1);
      chk("R2", "tap_data", tap_data, 16'h1111);
      chk("R2", "filt_busy", filt_busy, 1);
      @(negedge clk);
      chk("R2", "tap_load pulse end", tap_load, 0);
      pulse_done();
      chk("R2", "busy after done", filt_busy, 0);
      send(1'b1, 16'h2222);
      chk("R3", "ts_valid", ts_valid, 1);
      chk("R3", "ts_data", ts_data, 16'h2222);
      chk("R3", "no tap on stamp", tap_load, 0);
      @(negedge clk);
      chk("R3", "ts held", ts_valid, 1);
      pulse_take();
      chk("R3", "ts released", ts_valid, 0);
   endtask

   task automatic t_sts();
      do_reset();
      send(1'b0, 16'hA001);
      send(1'b1, 16'hB002);
      send(1'b0, 16'hC003);
      chk("R5", "ovr_flag", ovr_flag, 0);
      chk("R5", "buf_full", buf_full, 1);
      chk("R5", "ts_data", ts_data, 16'hB002);
      chk("R5", "tap_data first", tap_data, 16'hA001);
      pulse_done();
      chk("R4", "busy dropped", filt_busy, 0);
      chk("R4", "still buffered", buf_full, 1);
      @(negedge clk);
      chk("R4", "drain tap_load", tap_load, 1);
      chk("R4", "drain tap_data", tap_data, 16'hC003);
      chk("R4", "drain busy", filt_busy, 1);
      chk("R4", "drain empty", buf_full, 0);
   endtask

   task automatic t_ovr_busy();
      do_reset();
      send(1'b0, 16'h0A0A);
      send(1'b0, 16'h0B0B);
      chk("R5", "two samples no ovr", ovr_flag, 0);
      send(1'b1, 16'h0C0C);
      chk("R6", "ovr_flag", ovr_flag, 1);
      chk("R6", "stamp dropped", ts_valid, 0);
      chk("R6", "buffer kept", buf_full, 1);
      chk("R8", "err_irq masked", err_irq, 0);
      err_ie = 1'b1; #1;
      chk("R8", "err_irq", err_irq, 1);
      pulse_done();
      @(negedge clk);
      chk("R6", "kept sample forwarded", tap_data, 16'h0B0B);
      chk("R8", "ovr sticky", ovr_flag, 1);
      ovr_clr = 1'b1;
      @(negedge clk);
      ovr_clr = 1'b0;
      chk("R8", "ovr cleared", ovr_flag, 0);
      chk("R8", "err_irq cleared", err_irq, 0);
   endtask

   task automatic t_ovr_ts();
      do_reset();
      send(1'b1, 16'h5001);
      send(1'b1, 16'h5002);
      chk("R7", "no ovr yet", ovr_flag, 0);
      send(1'b0, 16'h5003);
      chk("R7", "ovr_flag", ovr_flag, 1);
      chk("R7", "ts reg kept", ts_data, 16'h5001);
      chk("R7", "sample dropped", filt_busy, 0);
      pulse_take();
      @(negedge clk);
      chk("R7", "buffered stamp drained", ts_data, 16'h5002);
      chk("R7", "ts_valid", ts_valid, 1);
      chk("R7", "buffer empty", buf_full, 0);
      chk("R7", "no sample ever", filt_busy, 0);
   endtask

   task automatic t_src();
      do_reset();
      src_sel = 1'b1;
      send(1'b0, 16'h7777);
      chk("R1", "cpu ignored", tap_load, 0);
      chk("R1", "cpu ignored busy", filt_busy, 0);
      cnv_valid = 1'b1; cnv_stamp = 1'b0; cnv_data = 16'h8888;
      @(negedge clk);
      cnv_valid = 1'b0;
      chk("R1", "cnv tap_load", tap_load, 1);
      chk("R1", "cnv tap_data", tap_data, 16'h8888);
      pulse_done();
      src_sel = 1'b0;
      cnv_valid = 1'b1; cnv_stamp = 1'b1; cnv_data = 16'h9999;
      @(negedge clk);
      cnv_valid = 1'b0; cnv_stamp = 1'b0;
      chk("R1", "cnv ignored", ts_valid, 0);
      chk("R1", "cnv ignored buf", buf_full, 0);
   endtask

   task automatic t_req();
      do_reset();
      dma_sel = 1'b1; empty_ie = 1'b1; #1;
      chk("R9", "dma_req", dma_req, 1);
      chk("R10", "irq suppressed by dma", empty_irq, 0);
      dma_sel = 1'b0; #1;
      chk("R10", "empty_irq", empty_irq, 1);
      chk("R9", "dma off", dma_req, 0);
      empty_ie = 1'b0; #1;
      chk("R10", "irq disabled", empty_irq, 0);
      empty_ie = 1'b1;
      @(negedge clk);
      send(1'b0, 16'h0001);
      send(1'b0, 16'h0002);
      chk("R10", "irq off when full", empty_irq, 0);
      do_reset();
      src_sel = 1'b1; dma_sel = 1'b1; empty_ie = 1'b1; #1;
      chk("R9", "dma off for converter", dma_req, 0);
      chk("R10", "irq off for converter", empty_irq, 0);
      @(negedge clk);
   endtask

   task automatic t_dflag();
      do_reset();
      send(1'b0, 16'h0042);
      chk("R11", "flag disabled", data_flag, 0);
      data_ie = 1'b1;
      send(1'b1, 16'h0043);
      chk("R11", "flag set", data_flag, 1);
      data_ie = 1'b0;
      pulse_take();
      pulse_done();
      chk("R11", "flag sticky after consume", data_flag, 1);
      data_clr = 1'b1;
      @(negedge clk);
      data_clr = 1'b0;
      chk("R11", "flag cleared", data_flag, 0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      do_reset();
      chk("R12", "initial busy", filt_busy, 0);
      t_reset();
      t_direct();
      t_sts();
      t_ovr_busy();
      t_ovr_ts();
      t_src();
      t_req();
      t_dflag();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule